// File: doc/BRIEF.md
# Keyed System Error Interrupt Collector

This block gathers one-cycle error pulses from a set of on-chip sources into a register of sticky flags. It raises a single interrupt pulse toward the processor. A global latch flag controls that pulse: the first flag set while the latch is open produces a pulse and closes the latch. No further pulse is produced until software clears the latch through the clear register. Clearing the latch re-arms the interrupt.

Software sees four 32-bit registers on a simple register bus. Their word offsets are fixed and decoded by the block. The flag register (0x10) can only be read. The clear register (0x12) is write-one-to-clear. The force register (0x14) is write-one-to-set. The mask register (0x16) can be read and written. The force and mask registers are protected by a key. A write to either one is accepted only when all byte strobes are set and bits 31:24 of the same write carry 0xA5.

Hardware events enter on a 32-bit vector. Bit i of that vector feeds flag bit i. Only the source positions take part: bits 1, 2 and 4 through 11.

Top module: `err_irq_collector`

## Requirements
- R1: After reset, the flag register and the mask register read 0 and `irq_o` is low.
- R2: An unmasked event pulse on a source position sets the matching flag bit at the next clock edge. The flag stays set until it is cleared.
- R3: Flag bit 3, flag bits 31:12 and the matching mask bits always read 0. This holds for hardware events and for forced writes alike.
- R4: A write to the clear register (offset 0x12) clears every flag bit, bit 0 included, whose data bit is 1 in a byte lane with its strobe set. Data bits of 0 change nothing, and the clear register always reads 0.
- R5: When a hardware event and a clear land on the same flag bit in the same cycle, the flag stays set.
- R6: A write to the force register (offset 0x14) sets the flag bits named by its 1 data bits. It is accepted only if all four strobes are set and bits 31:24 equal 0xA5; otherwise the whole write is ignored. Bit 0 of this register has no effect, and the register reads 0.
- R7: A write to the mask register (offset 0x16) is stored only for a full-strobe write with key 0xA5 in bits 31:24. Any other write leaves the mask unchanged. A read returns the stored mask bits with 0 in bits 31:24.
- R8: A mask bit of 1 stops a hardware event from setting the matching flag. A forced write still sets that flag.
- R9: When any flag is being set while the global flag (bit 0) is clear, `irq_o` goes high for exactly the next cycle and bit 0 reads 1.
- R10: While bit 0 stays set, `irq_o` remains low, even when further flags are set.
- R11: After bit 0 is cleared, the next flag set produces a new pulse. A flag set in the same cycle as the bit-0 clear also produces a pulse in the next cycle.
- R12: A read at any offset other than 0x10, 0x12, 0x14 and 0x16 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_ev | input | 32 | One-cycle error event pulses; bit i feeds flag bit i |
| bus_wen | input | 1 | Write strobe for the current bus cycle |
| bus_addr | input | 5 | Word offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte-lane enables of the write |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The bench drives four kinds of stimulus:
- Single event pulses.
- Events that coincide with a clear of the same bit or of the global flag.
- Forced writes with good keys, bad keys and partial strobes.
- Masked and unmasked events after a keyed mask write.

Each kind separates one pair of behaviours: sticky flags from level following, event priority from clear priority, a latched interrupt from a re-armed one, and a rejected keyed write from an accepted one. A behavioural model compares the interrupt output and the read data on every clock.

// File: rtl/errq_pkg.sv
package errq_pkg;
   typedef enum logic [2:0] {
      RS_NONE,
      RS_FLAG,
      RS_CLR,
      RS_SET,
      RS_MASK
   } reg_sel_e;
endpackage

// File: rtl/errq_wr_decode.sv
module errq_wr_decode
   import errq_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 5,
   parameter int KEY_W    = 8,
   parameter int KEY_LSB  = 24,
   parameter logic [KEY_W-1:0] KEY_VAL = 8'hA5,
   parameter logic [DATA_W-1:0] SRC_MASK = 32'h0000_0FF6,
   parameter int OFF_FLAG = 16,
   parameter int OFF_CLR  = 18,
   parameter int OFF_SET  = 20,
   parameter int OFF_MASK = 22
) (
   input  logic                  bus_wen,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   input  logic [DATA_W/8-1:0]   bus_wstrb,
   output reg_sel_e              rd_sel,
   output logic [DATA_W-1:0]     clr_bits,
   output logic [DATA_W-1:0]     set_bits,
   output logic                  mask_we,
   output logic [DATA_W-1:0]     mask_bits
);
   localparam int LANES = DATA_W / 8;
   localparam logic [DATA_W-1:0] CLR_REACH = SRC_MASK | DATA_W'(1);

   logic [DATA_W-1:0] lane_bits;
   logic              full_w;
   logic              key_ok;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_bits[l*8 +: 8] = {8{bus_wstrb[l]}};
   end

   assign full_w = &bus_wstrb;
   assign key_ok = (bus_wdata[KEY_LSB +: KEY_W] == KEY_VAL);

   always_comb begin
      if (bus_addr == ADDR_W'(OFF_FLAG))      rd_sel = RS_FLAG;
      else if (bus_addr == ADDR_W'(OFF_CLR))  rd_sel = RS_CLR;
      else if (bus_addr == ADDR_W'(OFF_SET))  rd_sel = RS_SET;
      else if (bus_addr == ADDR_W'(OFF_MASK)) rd_sel = RS_MASK;
      else                                    rd_sel = RS_NONE;
   end

   assign clr_bits  = (bus_wen && rd_sel == RS_CLR) ?
                      (bus_wdata & lane_bits & CLR_REACH) : '0;
   assign set_bits  = (bus_wen && rd_sel == RS_SET && full_w && key_ok) ?
                      (bus_wdata & SRC_MASK) : '0;
   assign mask_we   = bus_wen && (rd_sel == RS_MASK) && full_w && key_ok;
   assign mask_bits = bus_wdata & SRC_MASK;
endmodule

// File: rtl/errq_flag_bank.sv
module errq_flag_bank #(
   parameter int DATA_W = 32,
   parameter logic [DATA_W-1:0] SRC_MASK = 32'h0000_0FF6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] hw_ev,
   input  logic [DATA_W-1:0] clr_bits,
   input  logic [DATA_W-1:0] set_bits,
   input  logic              mask_we,
   input  logic [DATA_W-1:0] mask_bits,
   output logic [DATA_W-1:0] src_flags,
   output logic [DATA_W-1:0] mask_q,
   output logic              set_req_any
);
   logic [DATA_W-1:0] set_req;

   assign src_flags[0] = 1'b0;
   assign mask_q[0]    = 1'b0;
   assign set_req[0]   = 1'b0;

   for (genvar b = 1; b < DATA_W; b++) begin : g_bit
      if (SRC_MASK[b]) begin : g_live
         logic flag_r;
         logic mask_r;
         assign set_req[b] = (hw_ev[b] & ~mask_r) | set_bits[b];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flag_r <= 1'b0;
               mask_r <= 1'b0;
            end else begin
               flag_r <= (flag_r & ~clr_bits[b]) | set_req[b];
               if (mask_we) mask_r <= mask_bits[b];
            end
         end
         assign src_flags[b] = flag_r;
         assign mask_q[b]    = mask_r;
      end else begin : g_rsvd
         assign set_req[b]   = 1'b0;
         assign src_flags[b] = 1'b0;
         assign mask_q[b]    = 1'b0;
      end
   end

   assign set_req_any = |set_req;

   logic unused_rsvd;
   assign unused_rsvd = ^{hw_ev & ~SRC_MASK, clr_bits & ~SRC_MASK,
                          set_bits & ~SRC_MASK, mask_bits & ~SRC_MASK};
endmodule

// File: rtl/errq_irq_gen.sv
module errq_irq_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req_any,
   input  logic clr_glob,
   output logic glob_q,
   output logic irq_o
);
   logic glob_open;
   logic fire;

   assign glob_open = ~glob_q | clr_glob;
   assign fire      = set_req_any & glob_open;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_q <= 1'b0;
         irq_o  <= 1'b0;
      end else begin
         glob_q <= ~glob_open | fire;
         irq_o  <= fire;
      end
   end
endmodule

// File: rtl/err_irq_collector.sv
module err_irq_collector
   import errq_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 5,
   parameter int KEY_W    = 8,
   parameter int KEY_LSB  = 24,
   parameter logic [KEY_W-1:0] KEY_VAL = 8'hA5,
   parameter logic [DATA_W-1:0] SRC_MASK = 32'h0000_0FF6,
   parameter int OFF_FLAG = 16,
   parameter int OFF_CLR  = 18,
   parameter int OFF_SET  = 20,
   parameter int OFF_MASK = 22
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [DATA_W-1:0]     hw_ev,
   input  logic                  bus_wen,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   input  logic [DATA_W/8-1:0]   bus_wstrb,
   output logic [DATA_W-1:0]     bus_rdata,
   output logic                  irq_o
);
   localparam logic [DATA_W-1:0] KEY_FIELD = ((DATA_W'(1) << KEY_W) - DATA_W'(1)) << KEY_LSB;

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of bytes");
   end
   if (KEY_LSB + KEY_W > DATA_W) begin : g_bad_key
      $error("key field does not fit in the data word");
   end
   if (SRC_MASK[0]) begin : g_bad_src0
      $error("bit 0 is the global flag and cannot be a source");
   end
   if ((SRC_MASK & KEY_FIELD) != '0) begin : g_bad_overlap
      $error("source bits overlap the key field");
   end
   if (OFF_FLAG == OFF_CLR || OFF_FLAG == OFF_SET || OFF_FLAG == OFF_MASK ||
       OFF_CLR == OFF_SET || OFF_CLR == OFF_MASK || OFF_SET == OFF_MASK) begin : g_bad_off
      $error("register offsets must be distinct");
   end
   if (OFF_FLAG >= (1 << ADDR_W) || OFF_CLR >= (1 << ADDR_W) ||
       OFF_SET >= (1 << ADDR_W) || OFF_MASK >= (1 << ADDR_W)) begin : g_bad_range
      $error("register offset outside the address range");
   end

   reg_sel_e          rd_sel;
   logic [DATA_W-1:0] clr_bits;
   logic [DATA_W-1:0] set_bits;
   logic              mask_we;
   logic [DATA_W-1:0] mask_bits;
   logic [DATA_W-1:0] src_flags;
   logic [DATA_W-1:0] mask_q;
   logic              set_req_any;
   logic              glob_q;
   logic [DATA_W-1:0] flag_word;

   errq_wr_decode #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .KEY_W(KEY_W), .KEY_LSB(KEY_LSB),
      .KEY_VAL(KEY_VAL), .SRC_MASK(SRC_MASK), .OFF_FLAG(OFF_FLAG),
      .OFF_CLR(OFF_CLR), .OFF_SET(OFF_SET), .OFF_MASK(OFF_MASK)
   ) u_dec (
      .bus_wen(bus_wen), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wstrb(bus_wstrb), .rd_sel(rd_sel), .clr_bits(clr_bits),
      .set_bits(set_bits), .mask_we(mask_we), .mask_bits(mask_bits)
   );

   errq_flag_bank #(.DATA_W(DATA_W), .SRC_MASK(SRC_MASK)) u_bank (
      .clk(clk), .rst_n(rst_n), .hw_ev(hw_ev), .clr_bits(clr_bits),
      .set_bits(set_bits), .mask_we(mask_we), .mask_bits(mask_bits),
      .src_flags(src_flags), .mask_q(mask_q), .set_req_any(set_req_any)
   );

   errq_irq_gen u_irq (
      .clk(clk), .rst_n(rst_n), .set_req_any(set_req_any),
      .clr_glob(clr_bits[0]), .glob_q(glob_q), .irq_o(irq_o)
   );

   assign flag_word = src_flags | DATA_W'(glob_q);

   always_comb begin
      case (rd_sel)
         RS_FLAG: bus_rdata = flag_word;
         RS_MASK: bus_rdata = mask_q;
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/errq_checker.sv
module errq_checker #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 5,
   parameter int KEY_W    = 8,
   parameter int KEY_LSB  = 24,
   parameter logic [KEY_W-1:0] KEY_VAL = 8'hA5,
   parameter logic [DATA_W-1:0] SRC_MASK = 32'h0000_0FF6,
   parameter int OFF_FLAG = 16,
   parameter int OFF_CLR  = 18,
   parameter int OFF_SET  = 20,
   parameter int OFF_MASK = 22
) (
   input logic                clk,
   input logic                rst_n,
   input logic [DATA_W-1:0]   hw_ev,
   input logic                bus_wen,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [DATA_W/8-1:0] bus_wstrb,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic                irq_o,
   input logic [DATA_W-1:0]   flag_word,
   input logic [DATA_W-1:0]   mask_q
);
   logic [DATA_W-1:0] lanes;
   logic [DATA_W-1:0] clr_vec;
   logic [DATA_W-1:0] set_vec;
   logic              key_full;
   logic              mask_key_write;
   logic              mapped;

   always_comb begin
      for (int l = 0; l < DATA_W / 8; l++) lanes[l*8 +: 8] = {8{bus_wstrb[l]}};
   end

   assign key_full       = (&bus_wstrb) && (bus_wdata[KEY_LSB +: KEY_W] == KEY_VAL);
   assign clr_vec        = (bus_wen && bus_addr == ADDR_W'(OFF_CLR)) ? (bus_wdata & lanes) : '0;
   assign set_vec        = (bus_wen && bus_addr == ADDR_W'(OFF_SET) && key_full) ? (bus_wdata & SRC_MASK) : '0;
   assign mask_key_write = bus_wen && bus_addr == ADDR_W'(OFF_MASK) && key_full;
   assign mapped         = bus_addr == ADDR_W'(OFF_FLAG) || bus_addr == ADDR_W'(OFF_CLR) ||
                           bus_addr == ADDR_W'(OFF_SET)  || bus_addr == ADDR_W'(OFF_MASK);

   // R2: a flag that was set and not cleared stays set
   a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(flag_word) & ~$past(clr_vec) & SRC_MASK) & ~flag_word) == '0);

   // R2: an unmasked event shows up one edge later
   a_r2_event_lands: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hw_ev & ~mask_q & SRC_MASK) & ~flag_word) == '0);

   // R5: an event outranks a clear on the same bit
   a_r5_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hw_ev & ~mask_q & clr_vec & SRC_MASK) & ~flag_word) == '0);

   // R3: reserved positions stay zero
   a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_word & ~(SRC_MASK | DATA_W'(1))) == '0) && ((mask_q & ~SRC_MASK) == '0));

   // R7: without a keyed full write the mask holds
   a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_key_write |=> $stable(mask_q));

   // R8: a new source flag needs an unmasked event or a forced write
   a_r8_origin: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_word & SRC_MASK & ~$past(flag_word) & ~$past((hw_ev & ~mask_q) | set_vec)) == '0);

   // R9: a pulse always comes with the global flag set
   a_r9_pulse_latches: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> flag_word[0]);

   // R10: no pulse while the global flag was held set
   a_r10_quiet_latched: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flag_word[0]) && !$past(clr_vec[0])) |-> !irq_o);

   // R4 R6: clear and force registers read zero
   a_r4_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OFF_CLR) || bus_addr == ADDR_W'(OFF_SET)) |-> bus_rdata == '0);

   // R12: unmapped offsets read zero
   a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> bus_rdata == '0);
endmodule

bind err_irq_collector errq_checker #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .KEY_W(KEY_W), .KEY_LSB(KEY_LSB),
   .KEY_VAL(KEY_VAL), .SRC_MASK(SRC_MASK), .OFF_FLAG(OFF_FLAG),
   .OFF_CLR(OFF_CLR), .OFF_SET(OFF_SET), .OFF_MASK(OFF_MASK)
) u_errq_chk (
   .clk(clk), .rst_n(rst_n), .hw_ev(hw_ev), .bus_wen(bus_wen),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
   .bus_rdata(bus_rdata), .irq_o(irq_o), .flag_word(flag_word), .mask_q(mask_q)
);

// File: tb/err_irq_collector_test.sv
module err_irq_collector_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] SRC = 32'h0000_0FF6;
   localparam logic [4:0] A_FLAG = 5'h10;
   localparam logic [4:0] A_CLR  = 5'h12;
   localparam logic [4:0] A_SET  = 5'h14;
   localparam logic [4:0] A_MASK = 5'h16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] hw_ev = '0;
   logic        bus_wen = 1'b0;
   logic [4:0]  bus_addr = A_FLAG;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  bus_wstrb = 4'hF;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 0;
   string cur_req = "R1";

   // behavioural reference state
   logic [31:0] m_flags = '0;
   bit          m_glob = 0;
   logic [31:0] m_mask = '0;
   bit          m_irq = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   err_irq_collector uut (
      .clk(clk), .rst_n(rst_n), .hw_ev(hw_ev), .bus_wen(bus_wen),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
      .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   function automatic logic [31:0] model_read(logic [4:0] a);
      if (a == A_FLAG) return m_flags | {31'b0, m_glob};
      if (a == A_MASK) return m_mask;
      return '0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_flags = '0; m_glob = 0; m_mask = '0; m_irq = 0;
      end else begin
         logic [31:0] lanes, clr, frc, req;
         bit full, key, open;
         lanes = {{8{bus_wstrb[3]}}, {8{bus_wstrb[2]}}, {8{bus_wstrb[1]}}, {8{bus_wstrb[0]}}};
         full  = (bus_wstrb == 4'hF);
         key   = (bus_wdata[31:24] == 8'hA5);
         clr   = (bus_wen && bus_addr == A_CLR) ? (bus_wdata & lanes) : '0;
         frc   = (bus_wen && bus_addr == A_SET && full && key) ? (bus_wdata & SRC) : '0;
         req   = ((hw_ev & ~m_mask) | frc) & SRC;
         open  = !m_glob || clr[0];
         m_flags = (m_flags & ~clr & SRC) | req;
         m_irq   = (req != 0) && open;
         m_glob  = !open || m_irq;
         if (bus_wen && bus_addr == A_MASK && full && key) m_mask = bus_wdata & SRC;
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (!done) begin
         chk({cur_req, " irq vs model"}, {31'b0, irq_o}, {31'b0, m_irq});
         chk({cur_req, " rdata vs model"}, bus_rdata, model_read(bus_addr));
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog actual=%0d expected<=20000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic wr(logic [4:0] a, logic [31:0] d, logic [3:0] s, logic [31:0] ev);
      @(negedge clk);
      bus_wen = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s; hw_ev = ev;
      @(negedge clk);
      bus_wen = 1'b0; hw_ev = '0; bus_wstrb = 4'hF;
   endtask

   task automatic ev_pulse(logic [31:0] ev);
      @(negedge clk);
      hw_ev = ev;
      @(negedge clk);
      hw_ev = '0;
   endtask

   task automatic rd(logic [4:0] a, output logic [31:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(A_FLAG, v); chk("R1 flag after reset", v, 32'h0);
      rd(A_MASK, v); chk("R1 mask after reset", v, 32'h0);
      chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);

      cur_req = "R9";
      ev_pulse(32'h2);
      chk("R9 first event pulses", {31'b0, irq_o}, 32'h1);
      rd(A_FLAG, v); chk("R2 flag and global set", v, 32'h3);

      cur_req = "R10";
      ev_pulse(32'h20);
      chk("R10 no pulse while latched", {31'b0, irq_o}, 32'h0);
      rd(A_FLAG, v); chk("R2 second flag sticky", v, 32'h23);

      cur_req = "R4";
      wr(A_CLR, 32'h0, 4'hF, '0);
      rd(A_FLAG, v); chk("R4 zero clear no effect", v, 32'h23);
      rd(A_CLR, v); chk("R4 clear reads zero", v, 32'h0);
      wr(A_CLR, 32'h1, 4'hF, '0);
      chk("R4 clearing global alone no pulse", {31'b0, irq_o}, 32'h0);
      rd(A_FLAG, v); chk("R4 global cleared", v, 32'h22);

      cur_req = "R11";
      ev_pulse(32'h80);
      chk("R11 re-armed pulse", {31'b0, irq_o}, 32'h1);
      wr(A_CLR, 32'h1, 4'hF, 32'h200);
      chk("R11 same-cycle clear and event pulses", {31'b0, irq_o}, 32'h1);
      rd(A_FLAG, v); chk("R11 flags after same-cycle", v, 32'h2A3);

      cur_req = "R5";
      wr(A_CLR, 32'h80, 4'hF, 32'h80);
      rd(A_FLAG, v); chk("R5 event beats clear", v, 32'h2A3);
      wr(A_CLR, 32'hFFFF_FFFF, 4'hF, '0);
      rd(A_FLAG, v); chk("R4 clear all", v, 32'h0);

      cur_req = "R6";
      wr(A_SET, 32'hA500_0100, 4'hF, '0);
      chk("R6 forced set pulses", {31'b0, irq_o}, 32'h1);
      rd(A_FLAG, v); chk("R6 forced flag", v, 32'h101);
      wr(A_CLR, 32'hFFFF_FFFF, 4'hF, '0);
      wr(A_SET, 32'hA500_0001, 4'hF, '0);
      rd(A_FLAG, v); chk("R6 bit0 not forceable", v, 32'h0);
      wr(A_SET, 32'h5A00_0100, 4'hF, '0);
      rd(A_FLAG, v); chk("R6 bad key ignored", v, 32'h0);
      wr(A_SET, 32'hA500_0100, 4'hB, '0);
      rd(A_FLAG, v); chk("R6 partial write ignored", v, 32'h0);
      rd(A_SET, v); chk("R6 force reads zero", v, 32'h0);

      cur_req = "R3";
      wr(A_SET, 32'hA500_1008, 4'hF, '0);
      rd(A_FLAG, v); chk("R3 reserved not forced", v, 32'h0);
      ev_pulse(32'h00FF_F008);
      rd(A_FLAG, v); chk("R3 reserved events dropped", v, 32'h0);

      cur_req = "R7";
      wr(A_MASK, 32'hA500_0010, 4'hF, '0);
      rd(A_MASK, v); chk("R7 mask stored key hidden", v, 32'h10);
      wr(A_MASK, 32'h5A00_00F0, 4'hF, '0);
      rd(A_MASK, v); chk("R7 bad key mask ignored", v, 32'h10);
      wr(A_MASK, 32'hA500_00F0, 4'h7, '0);
      rd(A_MASK, v); chk("R7 partial mask ignored", v, 32'h10);

      cur_req = "R8";
      ev_pulse(32'h10);
      chk("R8 masked event no pulse", {31'b0, irq_o}, 32'h0);
      rd(A_FLAG, v); chk("R8 masked event no flag", v, 32'h0);
      ev_pulse(32'h4);
      chk("R8 unmasked event pulses", {31'b0, irq_o}, 32'h1);
      rd(A_FLAG, v); chk("R8 unmasked event flag", v, 32'h5);
      wr(A_SET, 32'hA500_0010, 4'hF, '0);
      rd(A_FLAG, v); chk("R8 force overrides mask", v, 32'h15);

      cur_req = "R12";
      rd(5'h11, v); chk("R12 unmapped 0x11", v, 32'h0);
      rd(5'h00, v); chk("R12 unmapped 0x00", v, 32'h0);
      rd(5'h1F, v); chk("R12 unmapped 0x1F", v, 32'h0);

      repeat (2) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule